// File: doc/BRIEF.md
# Adaptive Transmit Start-Threshold Controller

This block decides the moment a transmit MAC may begin draining a frame from its transmit FIFO. While software keeps the transmitter enabled, it compares the FIFO byte count against a programmable start threshold and issues a single start strobe per frame. When a complete frame is already in the FIFO, transmission starts even if the count is below the threshold. A store-and-forward mode disregards the byte count and waits for the complete frame.

When the MAC reports an underflow, the controller stops the transmitter without any software action. It then raises the threshold one level, and only after the new level is in place does it restart. After the highest byte threshold, the next underflow moves the controller into store-and-forward, and it stays there. The underflow also raises write-one-to-clear status bits. These bits, together with a frame-completion bit, feed an abnormal summary, a normal summary and one interrupt line.

Top module: `tx_start_thresh_ctl`

## Requirements
- R1: After reset the threshold code is 0, store-and-forward is off, the transmitter is inactive, all status bits and summaries are 0, and no start strobe is given.
- R2: While active and armed, `tx_start` is high in the same cycle that `fifo_level` is at least 128 << `thr_code` bytes. The codes are 0=128, 1=256, 2=512 and 3=1024. A count one byte below the threshold gives no strobe.
- R3: `frame_whole` high starts a frame whatever the byte count. With `store_fwd` set, the byte count is ignored and only `frame_whole` starts a frame.
- R4: `tx_start` pulses for one cycle per frame. It re-arms on `tx_done`, or when the transmitter becomes active, and it is never high while the transmitter is inactive.
- R5: A rising edge of `mac_underflow` seen while active drops `tx_active` in the next cycle. The threshold changes one cycle later, while the transmitter is still inactive. `tx_active` returns in the cycle after that if `sw_run` is still high.
- R6: Successive underflows step the level 128 to 256, 256 to 512, 512 to 1024, and 1024 to store-and-forward. In store-and-forward, a further underflow changes neither `store_fwd` nor `thr_code`.
- R7: An underflow pulse several cycles long steps the threshold only once.
- R8: A configuration write (`cfg_we` with `cfg_code` and `cfg_sf`) takes effect on the next edge only while the transmitter is stopped by software. While active, the write is ignored.
- R9: A rising underflow edge sets status bit 0 (underflow) and bit 1 (transmitter stopped). `tx_done` sets bit 2 (frame complete). Writing `sts_clr_we` with a 1 in a bit of `sts_clr` clears that bit on the next edge. A new event in the same cycle wins over the clear. An underflow while stopped only reports status.
- R10: `sum_abnormal` is high whenever bit 0 or bit 1 is set, `sum_normal` whenever bit 2 is set, and `irq` whenever either summary is high.
- R11: `sw_run` rising makes `tx_active` high after the next edge, and `sw_run` falling makes it low after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | CNT_W | Bytes currently held in the transmit FIFO |
| frame_whole | input | 1 | A complete frame is held in the FIFO |
| mac_underflow | input | 1 | Underflow indication from the MAC |
| tx_done | input | 1 | Frame transmission finished |
| sw_run | input | 1 | Software transmitter enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_code | input | 2 | Threshold code to write |
| cfg_sf | input | 1 | Store-and-forward value to write |
| sts_clr_we | input | 1 | Status clear strobe |
| sts_clr | input | 3 | Status bits to clear (1 clears) |
| tx_start | output | 1 | Start-transmit strobe |
| tx_active | output | 1 | Transmitter running |
| thr_code | output | 2 | Current threshold code |
| store_fwd | output | 1 | Store-and-forward in force |
| status | output | 3 | {frame complete, stopped, underflow} |
| sum_abnormal | output | 1 | Abnormal summary |
| sum_normal | output | 1 | Normal summary |
| irq | output | 1 | Interrupt |

## Verification
`tx_start` is combinational, so the bench checks it in the same low clock phase in which it sets the FIFO inputs. The status bits, `tx_active` and configuration writes settle one edge after their cause, and the bench samples them at the following falling edge. The underflow sequence has three separate results: the transmitter is inactive one edge after the edge is captured, the threshold has moved after two edges, and the transmitter is active again after three. The bench checks each of these at its own falling edge, so a step that comes too early or too late is caught.

// File: rtl/tx_start_thresh_ctl.sv
module tx_start_thresh_ctl #(
  parameter int CNT_W      = 12,
  parameter int BASE_BYTES = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_level,
  input  logic             frame_whole,
  input  logic             mac_underflow,
  input  logic             tx_done,
  input  logic             sw_run,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_code,
  input  logic             cfg_sf,
  input  logic             sts_clr_we,
  input  logic [2:0]       sts_clr,
  output logic             tx_start,
  output logic             tx_active,
  output logic [1:0]       thr_code,
  output logic             store_fwd,
  output logic [2:0]       status,
  output logic             sum_abnormal,
  output logic             sum_normal,
  output logic             irq
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HALT, S_RESTART} st_t;

  st_t            st;
  logic           uf_q, armed;
  logic [CNT_W-1:0] thr_bytes;
  logic [2:0]     clr;

  wire uf_edge = mac_underflow & ~uf_q;

  assign thr_bytes = CNT_W'(BASE_BYTES) << thr_code;
  assign tx_active = (st == S_RUN);
  assign tx_start  = tx_active & armed &
                     (frame_whole | (~store_fwd & (fifo_level >= thr_bytes)));
  assign clr       = sts_clr_we ? sts_clr : 3'b000;

  assign sum_abnormal = status[0] | status[1];
  assign sum_normal   = status[2];
  assign irq          = sum_abnormal | sum_normal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      uf_q      <= 1'b0;
      armed     <= 1'b0;
      thr_code  <= 2'd0;
      store_fwd <= 1'b0;
      status    <= 3'b000;
    end else begin
      uf_q <= mac_underflow;

      if (tx_done)  armed <= 1'b1;
      if (tx_start) armed <= 1'b0;

      case (st)
        S_IDLE: begin
          if (cfg_we) begin
            thr_code  <= cfg_code;
            store_fwd <= cfg_sf;
          end
          if (sw_run) begin
            st    <= S_RUN;
            armed <= 1'b1;
          end
        end
        S_RUN: begin
          if (uf_edge)      st <= S_HALT;
          else if (!sw_run) st <= S_IDLE;
        end
        S_HALT: begin
          st <= S_RESTART;
          if (!store_fwd) begin
            if (thr_code == 2'd3) store_fwd <= 1'b1;
            else                  thr_code  <= thr_code + 2'd1;
          end
        end
        default: begin
          if (sw_run) begin
            st    <= S_RUN;
            armed <= 1'b1;
          end else begin
            st <= S_IDLE;
          end
        end
      endcase

      status[0] <= (status[0] & ~clr[0]) | uf_edge;
      status[1] <= (status[1] & ~clr[1]) | uf_edge;
      status[2] <= (status[2] & ~clr[2]) | tx_done;
    end
  end
endmodule

module tx_start_thresh_ctl_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_level,
  input logic             frame_whole,
  input logic             mac_underflow,
  input logic             tx_start,
  input logic             tx_active,
  input logic [1:0]       thr_code,
  input logic             store_fwd,
  input logic [2:0]       status,
  input logic             sum_abnormal,
  input logic             sum_normal
);
  a_r4_start_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> tx_active);

  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  a_r5_halt_after_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && mac_underflow && !$past(mac_underflow)) |=> !tx_active);

  a_r5_change_only_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_code != $past(thr_code) || store_fwd != $past(store_fwd)) |->
      (!tx_active && !$past(tx_active)));

  a_r9_status_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_underflow && !$past(mac_underflow)) |=> (status[0] && status[1]));

  a_r10_summaries: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] |-> sum_abnormal) and (status[2] |-> sum_normal));
endmodule

bind tx_start_thresh_ctl tx_start_thresh_ctl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .frame_whole(frame_whole),
  .mac_underflow(mac_underflow), .tx_start(tx_start), .tx_active(tx_active),
  .thr_code(thr_code), .store_fwd(store_fwd), .status(status),
  .sum_abnormal(sum_abnormal), .sum_normal(sum_normal));

// File: tb/tx_start_thresh_ctl_bench.sv
module tx_start_thresh_ctl_bench;
  localparam int CNT_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CNT_W-1:0] fifo_level = '0;
  logic frame_whole = 0, mac_underflow = 0, tx_done = 0, sw_run = 0;
  logic cfg_we = 0, cfg_sf = 0, sts_clr_we = 0;
  logic [1:0] cfg_code = 0;
  logic [2:0] sts_clr = 0;
  logic tx_start, tx_active, store_fwd, sum_abnormal, sum_normal, irq;
  logic [1:0] thr_code;
  logic [2:0] status;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  tx_start_thresh_ctl #(.CNT_W(CNT_W)) u_tx_start_thresh_ctl (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .frame_whole(frame_whole),
    .mac_underflow(mac_underflow), .tx_done(tx_done), .sw_run(sw_run),
    .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_sf(cfg_sf),
    .sts_clr_we(sts_clr_we), .sts_clr(sts_clr), .tx_start(tx_start),
    .tx_active(tx_active), .thr_code(thr_code), .store_fwd(store_fwd),
    .status(status), .sum_abnormal(sum_abnormal), .sum_normal(sum_normal), .irq(irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk) sw_run = 0;
    @(negedge clk);
  endtask

  task automatic go_run();
    @(negedge clk) sw_run = 1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] c, input logic s);
    @(negedge clk) begin cfg_we = 1; cfg_code = c; cfg_sf = s; end
    @(negedge clk) cfg_we = 0;
  endtask

  task automatic done_pulse();
    @(negedge clk) tx_done = 1;
    @(negedge clk) tx_done = 0;
  endtask

  task automatic uf_pulse(input int len);
    @(negedge clk) mac_underflow = 1;
    repeat (len) @(negedge clk);
    mac_underflow = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 code", thr_code, 0);
    chk("R1 sf", store_fwd, 0);
    chk("R1 active", tx_active, 0);
    chk("R1 status", status, 0);
    chk("R1 irq", irq, 0);
    chk("R1 start", tx_start, 0);
  endtask

  task automatic t_run_stop();
    @(negedge clk) sw_run = 1;
    #1 chk("R11 not yet active", tx_active, 0);
    @(negedge clk) chk("R11 active", tx_active, 1);
    go_idle();
    chk("R11 stopped", tx_active, 0);
  endtask

  task automatic t_thresholds();
    for (int c = 0; c < 4; c++) begin
      go_idle();
      set_cfg(c[1:0], 0);
      fifo_level = CNT_W'((128 << c) - 1);
      frame_whole = 0;
      go_run();
      #1 chk("R2 below threshold", tx_start, 0);
      fifo_level = CNT_W'(128 << c);
      #1 chk("R2 at threshold", tx_start, 1);
      @(negedge clk) chk("R4 one strobe", tx_start, 0);
      done_pulse();
      #1 chk("R4 rearm on done", tx_start, 1);
      @(negedge clk) fifo_level = 0;
    end
  endtask

  task automatic t_whole_and_sf();
    go_idle();
    set_cfg(2'd3, 0);
    fifo_level = 12'd10;
    frame_whole = 0;
    go_run();
    #1 chk("R3 short no start", tx_start, 0);
    frame_whole = 1;
    #1 chk("R3 whole frame start", tx_start, 1);
    @(negedge clk) frame_whole = 0;
    go_idle();
    #1 chk("R4 no strobe idle", tx_start, 0);
    set_cfg(2'd0, 1);
    chk("R8 sf written", store_fwd, 1);
    fifo_level = 12'd2000;
    go_run();
    #1 chk("R3 sf ignores level", tx_start, 0);
    frame_whole = 1;
    #1 chk("R3 sf whole start", tx_start, 1);
    @(negedge clk) begin frame_whole = 0; fifo_level = 0; end
  endtask

  task automatic t_escalate();
    go_idle();
    set_cfg(2'd0, 0);
    @(negedge clk) sts_clr_we = 1; sts_clr = 3'b111;
    @(negedge clk) sts_clr_we = 0;
    go_run();
    @(negedge clk) mac_underflow = 1;
    @(negedge clk);
    chk("R5 halted", tx_active, 0);
    chk("R5 code not yet", thr_code, 0);
    chk("R9 underflow bit", status[0], 1);
    chk("R9 stopped bit", status[1], 1);
    chk("R10 abnormal", sum_abnormal, 1);
    chk("R10 irq", irq, 1);
    @(negedge clk);
    chk("R5 still halted", tx_active, 0);
    chk("R6 step 256", thr_code, 1);
    @(negedge clk);
    chk("R5 restarted", tx_active, 1);
    mac_underflow = 0;
    @(negedge clk) chk("R7 long pulse one step", thr_code, 1);
    uf_pulse(1);
    chk("R6 step 512", thr_code, 2);
    uf_pulse(1);
    chk("R6 step 1024", thr_code, 3);
    chk("R6 no sf yet", store_fwd, 0);
    uf_pulse(1);
    chk("R6 to sf", store_fwd, 1);
    chk("R5 running again", tx_active, 1);
    uf_pulse(1);
    chk("R6 sf sticky", store_fwd, 1);
    chk("R6 code kept", thr_code, 3);
  endtask

  task automatic t_cfg_ignored();
    @(negedge clk) begin cfg_we = 1; cfg_code = 0; cfg_sf = 0; end
    @(negedge clk) cfg_we = 0;
    chk("R8 ignored code", thr_code, 3);
    chk("R8 ignored sf", store_fwd, 1);
    go_idle();
    set_cfg(2'd1, 0);
    chk("R8 idle write code", thr_code, 1);
    chk("R8 idle write sf", store_fwd, 0);
  endtask

  task automatic t_status();
    @(negedge clk) begin sts_clr_we = 1; sts_clr = 3'b001; end
    @(negedge clk) sts_clr_we = 0;
    chk("R9 clear underflow", status, 3'b010);
    chk("R10 abnormal kept", sum_abnormal, 1);
    @(negedge clk) begin sts_clr_we = 1; sts_clr = 3'b010; end
    @(negedge clk) sts_clr_we = 0;
    chk("R10 abnormal off", sum_abnormal, 0);
    done_pulse();
    chk("R9 done bit", status, 3'b100);
    chk("R10 normal", sum_normal, 1);
    chk("R10 irq normal", irq, 1);
    @(negedge clk) begin sts_clr_we = 1; sts_clr = 3'b100; mac_underflow = 1; end
    @(negedge clk) begin sts_clr_we = 0; mac_underflow = 0; end
    chk("R9 set beats clear", status, 3'b011);
    chk("R9 idle underflow no step", thr_code, 1);
    chk("R9 idle stays stopped", tx_active, 0);
    @(negedge clk) begin sts_clr_we = 1; sts_clr = 3'b111; end
    @(negedge clk) sts_clr_we = 0;
    chk("R10 irq off", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_run_stop();
    t_thresholds();
    t_whole_and_sf();
    t_escalate();
    t_cfg_ignored();
    t_status();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule